// File: doc/BRIEF.md
# Framed Serial Command Receiver with Chained Output

This block receives fixed-length command words on a three-wire serial control port and hands each complete word to the register logic. An active-low frame strobe brackets every word. The data line is sampled on each falling edge of the serial clock while the frame is open, with the most significant bit first. The word is committed only when the strobe returns high, and only if exactly the frame length of falling edges was seen. A frame of any other length is dropped without a trace.

The serial output has two uses, and both change on the rising serial clock edge. In chained mode it presents the shift register, so the word received in one frame leaves the block during the next frame and can feed a downstream device. For a readback, the register logic decodes a request from a committed word, places the selected register contents on the parallel readback port and raises a request. At the start of the following frame, which carries a no-op, the block loads those contents and shifts them out. When neither use is active, and whenever the frame is closed, the output is held low.

The whole block runs on the system clock. The serial clock, strobe and data are brought in through a synchroniser chain and edge-detected, so the system clock must be at least four times the serial clock rate.

Top module: `sframe_rx`

## Requirements
- R1: A committed word carries the first sampled bit of its frame in bit FRAME_BITS-1 and the last sampled bit in bit 0. Data is sampled on falling SCLK edges while SYNC is low.
- R2: word_valid_o is high for exactly one clock cycle per accepted frame, and only after SYNC rises. word_o changes only together with that pulse, and never when the last bit arrives.
- R3: A frame that closes after fewer or more than FRAME_BITS falling SCLK edges raises no pulse and leaves word_o unchanged.
- R4: Falling SCLK edges while SYNC is high do not shift data. The shift register keeps what the last frame left in it, which is observable on sdo_o in the next chained frame.
- R5: sdo_o is 0 while SYNC is high. It is also 0 during a frame in which chain_en_i is 0 and no readback was requested at the frame start.
- R6: With chain_en_i = 1, during a frame sdo_o presents, MSB first, the FRAME_BITS bits that were in the shift register at the start of that frame. Each new bit appears after a rising SCLK edge, so it is valid at the following falling edge.
- R7: If rb_req_i = 1 when SYNC falls, rb_data_i is loaded and shifted out MSB first on sdo_o during that frame, with its MSB valid at the first falling edge. This holds whatever the value of chain_en_i.
- R8: After reset, word_o = 0, word_valid_o = 0 and sdo_o = 0.
- R9: With SYNC_STAGES = 2, word_valid_o is high in the cycle after the third rising clk edge that follows SYNC going high (SYNC_STAGES+1 edges in general).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock, asynchronous to clk |
| sync_n_i | input | 1 | Frame strobe, active low |
| sdin_i | input | 1 | Serial data in |
| chain_en_i | input | 1 | 1 = serial output passes the shift register through |
| rb_req_i | input | 1 | 1 at frame start = shift out rb_data_i in this frame |
| rb_data_i | input | FRAME_BITS | Readback register contents |
| sdo_o | output | 1 | Serial data out, 0 when idle |
| word_valid_o | output | 1 | One-cycle pulse: word_o was just committed |
| word_o | output | FRAME_BITS | Last accepted command word |

## Verification
The hardest state to reach from the ports is a shift register that was spared by stray serial clock edges while the strobe was high. Its contents only become visible one frame later. The stimulus therefore commits a word with chaining on, toggles the serial clock with the data line high while the frame is closed, and then opens a chained frame whose output must replay the earlier word bit for bit. Readback priority is reached by raising the request with chaining still enabled, so that the shift-out must come from the parallel port rather than from the previously received word.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  // saturating bit counter step
  function automatic int sat_inc(input int v, input int lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // a frame counts only when its length matches exactly
  function automatic logic frame_complete(input int cnt, input int bits);
    return (cnt == bits);
  endfunction

  // serial output gating: frame open and one of the two uses active
  function automatic logic sdo_gate(input logic bit_val, input logic open,
                                    input logic chain, input logic rb);
    return bit_val & open & (chain | rb);
  endfunction

endpackage

// File: rtl/sfr_edge.sv
module sfr_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic sync_n_i,
  input  logic sdin_i,
  output logic sclk_fall_o,
  output logic sclk_rise_o,
  output logic open_o,
  output logic close_o,
  output logic sdin_s_o
);
  logic [STAGES:0]   sclk_q;
  logic [STAGES:0]   sync_q;
  logic [STAGES-1:0] sdin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '1;
      sync_q <= '1;
      sdin_q <= '0;
    end else begin
      sclk_q <= {sclk_q[STAGES-1:0], sclk_i};
      sync_q <= {sync_q[STAGES-1:0], sync_n_i};
      sdin_q <= {sdin_q[STAGES-2:0], sdin_i};
    end
  end

  logic sclk_cur, sclk_prv, sync_cur, sync_prv, low;
  assign sclk_cur = sclk_q[STAGES-1];
  assign sclk_prv = sclk_q[STAGES];
  assign sync_cur = sync_q[STAGES-1];
  assign sync_prv = sync_q[STAGES];
  assign low      = ~sync_cur;

  assign sclk_fall_o = sclk_prv & ~sclk_cur & low;
  assign sclk_rise_o = ~sclk_prv & sclk_cur & low;
  assign open_o      = sync_prv & ~sync_cur;
  assign close_o     = ~sync_prv & sync_cur;
  assign sdin_s_o    = sdin_q[STAGES-1];
endmodule

// File: rtl/sfr_shift.sv
module sfr_shift #(
  parameter int FRAME_BITS = 24,
  parameter int CNT_W      = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fall_i,
  input  logic                  open_i,
  input  logic                  close_i,
  input  logic                  sdin_i,
  input  logic                  load_i,
  input  logic [FRAME_BITS-1:0] load_data_i,
  output logic                  sr_msb_o,
  output logic [CNT_W-1:0]      cnt_o,
  output logic [FRAME_BITS-1:0] word_o,
  output logic                  word_valid_o
);
  localparam int CNT_LIM = FRAME_BITS + 1;

  logic [FRAME_BITS-1:0] sr;
  logic [CNT_W-1:0]      cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr           <= '0;
      cnt          <= '0;
      word_o       <= '0;
      word_valid_o <= 1'b0;
    end else begin
      word_valid_o <= 1'b0;
      if (open_i) begin
        cnt <= '0;
        if (load_i) sr <= load_data_i;
      end else if (close_i) begin
        if (sfr_pkg::frame_complete(int'(cnt), FRAME_BITS)) begin
          word_o       <= sr;
          word_valid_o <= 1'b1;
        end
      end else if (fall_i) begin
        sr  <= {sr[FRAME_BITS-2:0], sdin_i};
        cnt <= CNT_W'(sfr_pkg::sat_inc(int'(cnt), CNT_LIM));
      end
    end
  end

  assign sr_msb_o = sr[FRAME_BITS-1];
  assign cnt_o    = cnt;
endmodule

// File: rtl/sfr_sdo.sv
module sfr_sdo (
  input  logic clk,
  input  logic rst_n,
  input  logic open_i,
  input  logic close_i,
  input  logic rise_i,
  input  logic rb_req_i,
  input  logic chain_en_i,
  input  logic ld_msb_i,
  input  logic sr_msb_i,
  output logic sdo_o,
  output logic frame_open_o,
  output logic rb_active_o
);
  logic sdo_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo_r        <= 1'b0;
      frame_open_o <= 1'b0;
      rb_active_o  <= 1'b0;
    end else if (open_i) begin
      frame_open_o <= 1'b1;
      rb_active_o  <= rb_req_i;
      sdo_r        <= rb_req_i ? ld_msb_i : sr_msb_i;
    end else if (close_i) begin
      frame_open_o <= 1'b0;
      rb_active_o  <= 1'b0;
    end else if (rise_i) begin
      sdo_r <= sr_msb_i;
    end
  end

  assign sdo_o = sfr_pkg::sdo_gate(sdo_r, frame_open_o, chain_en_i, rb_active_o);
endmodule

// File: rtl/sframe_rx.sv
module sframe_rx #(
  parameter int FRAME_BITS  = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk_i,
  input  logic                  sync_n_i,
  input  logic                  sdin_i,
  input  logic                  chain_en_i,
  input  logic                  rb_req_i,
  input  logic [FRAME_BITS-1:0] rb_data_i,
  output logic                  sdo_o,
  output logic                  word_valid_o,
  output logic [FRAME_BITS-1:0] word_o
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);

  // named internal events, also watched by the checker
  logic             ev_fall, ev_rise, ev_open, ev_close;
  logic             sdin_s, sr_msb, frame_open, rb_active;
  logic [CNT_W-1:0] bit_cnt;

  sfr_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .sclk_i(sclk_i), .sync_n_i(sync_n_i), .sdin_i(sdin_i),
    .sclk_fall_o(ev_fall), .sclk_rise_o(ev_rise),
    .open_o(ev_open), .close_o(ev_close), .sdin_s_o(sdin_s)
  );

  sfr_shift #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .fall_i(ev_fall), .open_i(ev_open), .close_i(ev_close),
    .sdin_i(sdin_s), .load_i(rb_req_i), .load_data_i(rb_data_i),
    .sr_msb_o(sr_msb), .cnt_o(bit_cnt),
    .word_o(word_o), .word_valid_o(word_valid_o)
  );

  sfr_sdo u_sdo (
    .clk(clk), .rst_n(rst_n),
    .open_i(ev_open), .close_i(ev_close), .rise_i(ev_rise),
    .rb_req_i(rb_req_i), .chain_en_i(chain_en_i),
    .ld_msb_i(rb_data_i[FRAME_BITS-1]), .sr_msb_i(sr_msb),
    .sdo_o(sdo_o), .frame_open_o(frame_open), .rb_active_o(rb_active)
  );
endmodule

// File: rtl/sframe_rx_chk.sv
module sframe_rx_chk #(
  parameter int FRAME_BITS = 24,
  parameter int CNT_W      = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  chain_en_i,
  input logic                  sdo_o,
  input logic                  word_valid_o,
  input logic [FRAME_BITS-1:0] word_o,
  input logic                  ev_close,
  input logic                  ev_rise,
  input logic                  frame_open,
  input logic                  rb_active,
  input logic [CNT_W-1:0]      bit_cnt
);
  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |=> !word_valid_o);

  p_valid_after_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> $past(ev_close));

  p_full_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> ($past(bit_cnt) == CNT_W'(FRAME_BITS)));

  p_word_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid_o |-> $stable(word_o));

  p_sdo_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_open |-> !sdo_o);

  p_sdo_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_o |-> (chain_en_i || rb_active));

  p_sdo_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_open && $past(frame_open) && $stable(chain_en_i) && !$stable(sdo_o))
      |-> $past(ev_rise));
endmodule

bind sframe_rx sframe_rx_chk #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .chain_en_i(chain_en_i), .sdo_o(sdo_o),
  .word_valid_o(word_valid_o), .word_o(word_o), .ev_close(ev_close),
  .ev_rise(ev_rise), .frame_open(frame_open), .rb_active(rb_active),
  .bit_cnt(bit_cnt)
);

// File: tb/sframe_rx_test.sv
module sframe_rx_test;
  localparam int PERIOD = 10;
  localparam int HALF   = 4;   // serial clock half period in clk cycles
  localparam int W      = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, sync_n = 1'b1, sdin = 1'b0;
  logic chain_en = 1'b0, rb_req = 1'b0;
  logic [W-1:0] rb_data = '0;
  logic sdo, wvalid;
  logic [W-1:0] word;

  int checks = 0;
  int errors = 0;
  int npulse = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  sframe_rx uut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sync_n_i(sync_n), .sdin_i(sdin),
    .chain_en_i(chain_en), .rb_req_i(rb_req), .rb_data_i(rb_data),
    .sdo_o(sdo), .word_valid_o(wvalid), .word_o(word)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit hs[$], hy[$], hd[$];
  bit mq[$];
  int m_cnt;
  logic [W-1:0] m_word;
  bit m_valid, m_sdo, m_frame, m_rb;

  always @(posedge clk) begin
    if (!rst_n) begin
      hs = '{1, 1, 1, 1}; hy = '{1, 1, 1, 1}; hd = '{0, 0, 0, 0};
      mq.delete();
      for (int i = 0; i < W; i++) mq.push_back(1'b0);
      m_cnt = 0; m_word = '0; m_valid = 0; m_sdo = 0; m_frame = 0; m_rb = 0;
    end else begin
      bit a_s, b_s, a_y, b_y, a_d;
      void'(hs.pop_front()); hs.push_back(sclk);
      void'(hy.pop_front()); hy.push_back(sync_n);
      void'(hd.pop_front()); hd.push_back(sdin);
      a_s = hs[1]; b_s = hs[0]; a_y = hy[1]; b_y = hy[0]; a_d = hd[1];
      m_valid = 0;
      if (b_y && !a_y) begin
        m_cnt = 0; m_frame = 1; m_rb = rb_req;
        if (rb_req) begin
          mq.delete();
          for (int i = W - 1; i >= 0; i--) mq.push_back(rb_data[i]);
        end
        m_sdo = mq[0];
      end else if (!b_y && a_y) begin
        if (m_cnt == W) begin
          for (int i = 0; i < W; i++) m_word[W-1-i] = mq[i];
          m_valid = 1;
        end
        m_frame = 0; m_rb = 0;
      end else if (!a_y) begin
        if (b_s && !a_s) begin
          mq.push_back(a_d); void'(mq.pop_front());
          if (m_cnt < W + 1) m_cnt++;
        end
        if (!b_s && a_s) m_sdo = mq[0];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_sdo;
      exp_sdo = m_sdo & m_frame & (chain_en | m_rb);
      chk(word === m_word, "R1", "model word_o", 32'(word), 32'(m_word));
      chk(wvalid === m_valid, "R2", "model word_valid_o", 32'(wvalid), 32'(m_valid));
      chk(sdo === exp_sdo, "R6", "model sdo_o", 32'(sdo), 32'(exp_sdo));
      if (wvalid) npulse++;
    end
  end

  // ---------------- stimulus ----------------
  int pulses_before_close;
  int lat;

  task automatic frame(input logic [W-1:0] w, input int nbits,
                       output logic [W-1:0] got, output bit any_sdo);
    got = '0; any_sdo = 0;
    sync_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdin = (i < W) ? w[W-1-i] : 1'b1;
      repeat (HALF) @(negedge clk);
      got = {got[W-2:0], sdo};
      any_sdo |= sdo;
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
    end
    repeat (HALF) @(negedge clk);
    any_sdo |= sdo;
    pulses_before_close = npulse;
    sync_n = 1'b1;
    lat = 0;
    for (int c = 1; c <= 4 * HALF; c++) begin
      @(negedge clk);
      if (wvalid && lat == 0) lat = c;
    end
  endtask

  initial begin
    logic [W-1:0] got, saved;
    bit any;
    int p0;
    repeat (5) @(negedge clk);
    chk(word === '0, "R8", "reset word_o", 32'(word), 0);
    chk(wvalid === 1'b0, "R8", "reset word_valid_o", 32'(wvalid), 0);
    chk(sdo === 1'b0, "R8", "reset sdo_o", 32'(sdo), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // plain frame, outputs quiet
    p0 = npulse;
    frame(24'hA5C396, W, got, any);
    chk(word === 24'hA5C396, "R1", "word after frame A", 32'(word), 32'h00A5C396);
    chk(pulses_before_close == p0, "R2", "no pulse before close", pulses_before_close, p0);
    chk(npulse == p0 + 1, "R2", "one pulse per frame", npulse, p0 + 1);
    chk(lat == 3, "R9", "commit latency", lat, 3);
    chk(any == 0, "R5", "sdo with no mode", 32'(any), 0);

    frame(24'h123456, W, got, any);
    chk(word === 24'h123456, "R1", "word after frame B", 32'(word), 32'h00123456);

    // wrong lengths
    p0 = npulse;
    frame(24'hFFFFFF, W - 1, got, any);
    chk(npulse == p0, "R3", "short frame pulse", npulse, p0);
    chk(word === 24'h123456, "R3", "short frame word", 32'(word), 32'h00123456);
    frame(24'h00FF00, W + 1, got, any);
    chk(npulse == p0, "R3", "long frame pulse", npulse, p0);
    chk(word === 24'h123456, "R3", "long frame word", 32'(word), 32'h00123456);

    // chained mode
    chain_en = 1'b1;
    frame(24'hC0FFEE, W, got, any);
    chk(word === 24'hC0FFEE, "R1", "word after frame D", 32'(word), 32'h00C0FFEE);
    chk(sdo === 1'b0, "R5", "sdo with sync high", 32'(sdo), 0);
    sdin = 1'b1;
    for (int k = 0; k < 10; k++) begin
      sclk = 1'b0; repeat (HALF) @(negedge clk);
      sclk = 1'b1; repeat (HALF) @(negedge clk);
    end
    sdin = 1'b0;
    frame(24'h0F1E2D, W, got, any);
    chk(got === 24'hC0FFEE, "R4", "idle edges ignored", 32'(got), 32'h00C0FFEE);
    chk(got === 24'hC0FFEE, "R6", "chained output", 32'(got), 32'h00C0FFEE);
    chk(word === 24'h0F1E2D, "R1", "word after frame E", 32'(word), 32'h000F1E2D);

    // readback, chaining off
    chain_en = 1'b0;
    rb_data = 24'h5AA5C3; rb_req = 1'b1;
    frame(24'h000000, W, got, any);
    rb_req = 1'b0;
    chk(got === 24'h5AA5C3, "R7", "readback shift-out", 32'(got), 32'h005AA5C3);
    chk(word === 24'h000000, "R1", "no-op word", 32'(word), 0);

    // readback wins over chaining
    chain_en = 1'b1;
    rb_data = 24'h3C96E1; rb_req = 1'b1;
    saved = 24'h000000;
    frame(24'h800001, W, got, any);
    rb_req = 1'b0;
    chk(got === 24'h3C96E1, "R7", "readback priority", 32'(got), 32'h003C96E1);
    chk(got !== saved, "R7", "not chained contents", 32'(got), 32'(~saved));

    // back to no mode: output silent during a frame
    chain_en = 1'b0;
    frame(24'hFFFFFF, W, got, any);
    chk(any == 0, "R5", "sdo silent without mode", 32'(any), 0);
    chk(word === 24'hFFFFFF, "R1", "all-ones word", 32'(word), 32'h00FFFFFF);

    repeat (10) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule